// File: doc/BRIEF.md
# Configurable Port Input Capture Cells

This block holds twenty capture cells that sit between three I/O ports and the input bus of a programmable logic array. Port A and port B each give eight pins and port C gives four. Each cell has its own mode setting. A cell can pass its pin straight through. It can act as a level-sensitive latch. It can also act as an edge-triggered register.

The capture signal is chosen per group of four neighbouring pins. A group can use an enable term from the logic array, or it can use the CPU address strobe. A group covers bits 3..0 or bits 7..4 of one port. Port C forms a single group. Rising edges of the chosen signal are detected in the system clock domain.

All twenty cell outputs drive the array input bus together. The CPU can also read one port at a time through an 8-bit read port. Mode and source settings are static configuration inputs.

Top module: `port_capture_cells`

## Requirements
- R1: `bus_o` places port A cells at bits 7..0, port B cells at bits 15..8 and port C cells at bits 19..16. Pin k of a port maps to bit k of its slice.
- R2: A cell whose 2-bit mode field `cfg_mode_i[2c+1:2c]` is 00 or 11 drives its pin value to its output in the same cycle.
- R3: In mode 01 (latch), the output equals the pin while the group's selected enable is high. While the enable is low, the output holds the pin value sampled at the last clock edge at which the enable was high.
- R4: In mode 10 (register), the cell stores its pin at a clock edge where the selected enable is high and was low at the previous edge. The new value appears right after that edge. At all other edges the output holds.
- R5: Group g takes `addr_strobe_i` when `cfg_src_i[g]` is 1, and `arr_term_i[g]` when it is 0. Group 0 is A[3:0], group 1 is A[7:4], group 2 is B[3:0], group 3 is B[7:4] and group 4 is C[3:0].
- R6: An enable edge in one group changes only the four cells of that group.
- R7: `rd_data_o` is combinational and depends on `rd_sel_i`. Value 0 returns port A and value 1 returns port B. Value 2 returns port C in bits 3..0, with bits 7..4 reading 0. Value 3 returns 0.
- R8: Reset (`rst_ni` low) clears every stored cell value and the edge history to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_a_i | input | 8 | Port A pin values |
| pin_b_i | input | 8 | Port B pin values |
| pin_c_i | input | 4 | Port C pin values |
| arr_term_i | input | 5 | Logic-array enable term, one per group |
| addr_strobe_i | input | 1 | CPU address strobe |
| cfg_mode_i | input | 40 | Two mode bits per cell |
| cfg_src_i | input | 5 | Capture source per group, 1 selects the strobe |
| rd_sel_i | input | 2 | Port chosen for CPU read |
| bus_o | output | 20 | Cell outputs to the array input bus |
| rd_data_o | output | 8 | CPU read data |

## Verification
Pass-through outputs, transparent latch outputs and CPU read data are due in the same cycle as the input change. The bench drives inputs just after the falling edge and samples one nanosecond later. Register captures and latch holds depend on the last rising edge. For these, the bench keeps a model of stored values and edge history that it updates at each rising edge from the stated rules. It then compares at the next sample point. The directed register checks look once before the capturing edge, to confirm that nothing moved, and once after it.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
    typedef enum logic [1:0] {
        MODE_PASS     = 2'b00,
        MODE_LATCH    = 2'b01,
        MODE_REG      = 2'b10,
        MODE_PASS_ALT = 2'b11
    } cell_mode_e;

    localparam int MODE_W = 2;
endpackage

// File: rtl/pcc_enable_sel.sv
module pcc_enable_sel #(
    parameter int N_GRP = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_GRP-1:0] arr_term_i,
    input  logic             strobe_i,
    input  logic [N_GRP-1:0] src_sel_i,
    output logic [N_GRP-1:0] en_o,
    output logic [N_GRP-1:0] rise_o
);
    typedef struct packed {
        logic [N_GRP-1:0] prev;
    } sel_state_t;

    sel_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        en_o   = (src_sel_i & {N_GRP{strobe_i}}) | (~src_sel_i & arr_term_i);
        rise_o = en_o & ~st_q.prev;
        st_d.prev = en_o;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_chk
        AST_RISE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rise_o[g] |-> en_o[g]) else $error("rise without enable"); // R4
        AST_RISE_NOT_TWICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rise_o[g] |=> !rise_o[g]) else $error("rise repeated"); // R4
    end
endmodule

// File: rtl/pcc_cell_group.sv
module pcc_cell_group
    import pcc_pkg::*;
#(
    parameter int GRP_W = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [GRP_W-1:0]      pin_i,
    input  logic [MODE_W*GRP_W-1:0] mode_i,
    input  logic                  en_i,
    input  logic                  rise_i,
    output logic [GRP_W-1:0]      out_o
);
    typedef struct packed {
        logic [GRP_W-1:0] store;
    } grp_state_t;

    grp_state_t st_d, st_q;

    always_comb begin
        cell_mode_e m;
        st_d  = st_q;
        out_o = '0;
        for (int i = 0; i < GRP_W; i++) begin
            m = cell_mode_e'(mode_i[MODE_W*i +: MODE_W]);
            case (m)
                MODE_LATCH: begin
                    if (en_i) st_d.store[i] = pin_i[i];
                    out_o[i] = en_i ? pin_i[i] : st_q.store[i];
                end
                MODE_REG: begin
                    if (rise_i) st_d.store[i] = pin_i[i];
                    out_o[i] = st_q.store[i];
                end
                default: out_o[i] = pin_i[i];
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar i = 0; i < GRP_W; i++) begin : g_chk
        AST_REG_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (mode_i[MODE_W*i +: MODE_W] == 2'b10 && rise_i)
            |=> (mode_i[MODE_W*i +: MODE_W] != 2'b10 || out_o[i] == $past(pin_i[i])))
            else $error("register capture missed"); // R4
        AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (mode_i[MODE_W*i +: MODE_W] == 2'b10 && !rise_i)
            |=> (mode_i[MODE_W*i +: MODE_W] != 2'b10 || $stable(out_o[i])))
            else $error("register output moved"); // R4
        AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (mode_i[MODE_W*i +: MODE_W] == 2'b01 && !en_i)
            |=> (mode_i[MODE_W*i +: MODE_W] != 2'b01 || en_i || $stable(out_o[i])))
            else $error("closed latch moved"); // R3
    end
endmodule

// File: rtl/pcc_read_mux.sv
module pcc_read_mux #(
    parameter int A_W = 8,
    parameter int B_W = 8,
    parameter int C_W = 4,
    parameter int D_W = 8,
    localparam int N_CELLS = A_W + B_W + C_W
) (
    input  logic [N_CELLS-1:0] cells_i,
    input  logic [1:0]         rd_sel_i,
    output logic [D_W-1:0]     rd_data_o
);
    always_comb begin
        rd_data_o = '0;
        case (rd_sel_i)
            2'd0:    rd_data_o[A_W-1:0] = cells_i[A_W-1:0];
            2'd1:    rd_data_o[B_W-1:0] = cells_i[A_W +: B_W];
            2'd2:    rd_data_o[C_W-1:0] = cells_i[A_W+B_W +: C_W];
            default: rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/port_capture_cells.sv
module port_capture_cells
    import pcc_pkg::*;
#(
    parameter int A_W   = 8,
    parameter int B_W   = 8,
    parameter int C_W   = 4,
    parameter int GRP_W = 4,
    parameter int D_W   = 8,
    localparam int N_CELLS = A_W + B_W + C_W,
    localparam int N_GRP   = N_CELLS / GRP_W
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [A_W-1:0]            pin_a_i,
    input  logic [B_W-1:0]            pin_b_i,
    input  logic [C_W-1:0]            pin_c_i,
    input  logic [N_GRP-1:0]          arr_term_i,
    input  logic                      addr_strobe_i,
    input  logic [MODE_W*N_CELLS-1:0] cfg_mode_i,
    input  logic [N_GRP-1:0]          cfg_src_i,
    input  logic [1:0]                rd_sel_i,
    output logic [N_CELLS-1:0]        bus_o,
    output logic [D_W-1:0]            rd_data_o
);
    logic [N_CELLS-1:0] cell_pin;
    logic [N_GRP-1:0]   grp_en;
    logic [N_GRP-1:0]   grp_rise;

    assign cell_pin = {pin_c_i, pin_b_i, pin_a_i};

    pcc_enable_sel #(.N_GRP(N_GRP)) u_sel (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .arr_term_i (arr_term_i),
        .strobe_i   (addr_strobe_i),
        .src_sel_i  (cfg_src_i),
        .en_o       (grp_en),
        .rise_o     (grp_rise)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        pcc_cell_group #(.GRP_W(GRP_W)) u_grp (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .pin_i  (cell_pin[g*GRP_W +: GRP_W]),
            .mode_i (cfg_mode_i[g*GRP_W*MODE_W +: GRP_W*MODE_W]),
            .en_i   (grp_en[g]),
            .rise_i (grp_rise[g]),
            .out_o  (bus_o[g*GRP_W +: GRP_W])
        );
    end

    pcc_read_mux #(.A_W(A_W), .B_W(B_W), .C_W(C_W), .D_W(D_W)) u_rd (
        .cells_i   (bus_o),
        .rd_sel_i  (rd_sel_i),
        .rd_data_o (rd_data_o)
    );

    for (genvar c = 0; c < N_CELLS; c++) begin : g_pass_chk
        AST_PASS_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cfg_mode_i[MODE_W*c] == cfg_mode_i[MODE_W*c+1]) |-> bus_o[c] == cell_pin[c])
            else $error("pass cell differs from pin"); // R2
    end

    AST_PORTC_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_sel_i == 2'd2) |-> rd_data_o[D_W-1:C_W] == '0)
        else $error("port C upper bits set"); // R7
    AST_IDLE_SEL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_sel_i == 2'd3) |-> rd_data_o == '0)
        else $error("unused select not zero"); // R7
endmodule

// File: tb/port_capture_cells_tb.sv
module port_capture_cells_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_a = '0, pin_b = '0;
    logic [3:0]  pin_c = '0;
    logic [4:0]  term = '0, src = '0;
    logic        strobe = 1'b0;
    logic [39:0] cfg = '0;
    logic [1:0]  rd_sel = '0;
    logic [19:0] bus;
    logic [7:0]  rd;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    port_capture_cells u_dut (
        .clk_i(clk), .rst_ni(rst_n), .pin_a_i(pin_a), .pin_b_i(pin_b), .pin_c_i(pin_c),
        .arr_term_i(term), .addr_strobe_i(strobe), .cfg_mode_i(cfg), .cfg_src_i(src),
        .rd_sel_i(rd_sel), .bus_o(bus), .rd_data_o(rd)
    );

    wire [19:0] pins = {pin_c, pin_b, pin_a};
    logic [19:0] m_store = '0;
    logic [4:0]  m_prev = '0;

    function automatic logic sel_en(int g);
        return src[g] ? strobe : term[g];
    endfunction

    // reference model: R3 latch update, R4 rising-edge capture, R5 source, R8 clear
    always @(posedge clk) begin
        if (!rst_n) begin
            m_store = '0;
            m_prev  = '0;
        end else begin
            for (int c = 0; c < 20; c++) begin
                if (cfg[2*c +: 2] == 2'b01 && sel_en(c/4)) m_store[c] = pins[c];
                if (cfg[2*c +: 2] == 2'b10 && sel_en(c/4) && !m_prev[c/4]) m_store[c] = pins[c];
            end
            for (int g = 0; g < 5; g++) m_prev[g] = sel_en(g);
        end
    end

    function automatic logic [19:0] exp_bus();
        logic [19:0] e;
        for (int c = 0; c < 20; c++) begin
            case (cfg[2*c +: 2])
                2'b01:   e[c] = sel_en(c/4) ? pins[c] : m_store[c];
                2'b10:   e[c] = m_store[c];
                default: e[c] = pins[c];
            endcase
        end
        return e;
    endfunction

    function automatic logic [7:0] exp_rd();
        case (rd_sel)
            2'd0: return pin_sel(0);
            2'd1: return pin_sel(1);
            2'd2: return pin_sel(2);
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] pin_sel(int p);
        logic [19:0] e;
        e = exp_bus();
        if (p == 0) return e[7:0];
        if (p == 1) return e[15:8];
        return {4'h0, e[19:16]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_bus();
        logic [19:0] e;
        string tag;
        e = exp_bus();
        tag = "R1";
        for (int c = 19; c >= 0; c--) begin
            if (bus[c] !== e[c]) begin
                case (cfg[2*c +: 2])
                    2'b01:   tag = "R3 latch";
                    2'b10:   tag = "R4 register";
                    default: tag = "R2 pass";
                endcase
            end
        end
        chk(bus === e, tag, 32'(bus), 32'(e));
    endtask

    initial begin
        logic [31:0] lf;
        lf = 32'h1F2E_3D4C;
        repeat (3) @(negedge clk);
        cfg = {20{2'b10}};
        pin_a = 8'hFF; pin_b = 8'hFF; pin_c = 4'hF;
        rst_n = 1'b1;
        #1;
        chk(bus === 20'h0, "R8 reset bus", 32'(bus), 0);
        chk(rd === 8'h0, "R8 reset read", 32'(rd), 0);

        // R6: rise on group 1 only
        @(negedge clk); term = 5'b00010; #1;
        chk(bus === 20'h0, "R4 before edge", 32'(bus), 0);
        @(negedge clk); #1;
        chk(bus === 20'h000F0, "R6 group isolation", 32'(bus), 32'h000F0);
        term = '0;

        // R5: group 0 on strobe ignores its array term
        @(negedge clk); src = 5'b00001; term = 5'b00001; #1;
        @(negedge clk); #1;
        chk(bus === 20'h000F0, "R5 term ignored", 32'(bus), 32'h000F0);
        strobe = 1'b1;
        @(negedge clk); #1;
        chk(bus === 20'h000FF, "R5 strobe capture", 32'(bus), 32'h000FF);
        strobe = 1'b0; term = '0; src = '0;

        // R3: latch transparency then hold
        @(negedge clk);
        cfg = {20{2'b01}}; term = 5'b11111;
        pin_a = 8'h3C; pin_b = 8'h81; pin_c = 4'h6; #1;
        chk(bus === 20'h6813C, "R3 transparent", 32'(bus), 32'h6813C);
        @(negedge clk); term = '0; pin_a = 8'hC3; pin_b = 8'h7E; pin_c = 4'h9; #1;
        chk(bus === 20'h6813C, "R3 hold", 32'(bus), 32'h6813C);

        // R1 layout and R7 read select
        @(negedge clk); cfg = '0; pin_a = 8'h5A; pin_b = 8'hC3; pin_c = 4'h9; #1;
        chk(bus === 20'h9C35A, "R1 layout", 32'(bus), 32'h9C35A);
        rd_sel = 2'd0; #1; chk(rd === 8'h5A, "R7 port A", 32'(rd), 32'h5A);
        rd_sel = 2'd1; #1; chk(rd === 8'hC3, "R7 port B", 32'(rd), 32'hC3);
        rd_sel = 2'd2; #1; chk(rd === 8'h09, "R7 port C", 32'(rd), 32'h09);
        rd_sel = 2'd3; #1; chk(rd === 8'h00, "R7 unused", 32'(rd), 32'h00);

        // sweep over mode patterns and source selections
        for (int ph = 0; ph < 8; ph++) begin
            @(negedge clk);
            for (int c = 0; c < 20; c++)
                cfg[2*c +: 2] = (ph < 4) ? 2'(ph) : 2'((c*3 + ph) % 4);
            src = 5'(ph * 11);
            for (int k = 0; k < 400; k++) begin
                if (k != 0) @(negedge clk);
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                pin_a = lf[7:0]; pin_b = lf[15:8]; pin_c = lf[19:16];
                term = lf[24:20]; strobe = lf[25]; rd_sel = 2'(k);
                #1;
                chk_bus();
                chk(rd === exp_rd(), "R7 read", 32'(rd), 32'(exp_rd()));
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule